// File: doc/BRIEF.md
# Iterative Shift-Add Vector Rotator for DCT Butterflies

This block rotates a signed two-dimensional vector by one of three fixed angles that occur in the odd part of an 8-point DCT: 3π/8, 3π/16 and π/16. It has a single shift-add stage. The stage's outputs are fed back into its inputs once per clock, so one set of adders serves every micro-rotation. Each step rotates either clockwise or counter-clockwise. The direction for each step is read from a constant sign table, indexed by the selected angle and the step number. No residual angle is kept, and no sign test is made on a residual angle.

The caller sets the vector, the angle code and the number of steps, and holds start high for one clock. The block accepts the request and runs the requested steps. It raises done for a single cycle, and then holds the result on its outputs until the next request is accepted. Using fewer steps gives lower latency at the cost of accuracy. The outputs still carry the CORDIC gain, about 1/0.60725 after the full eleven steps. The gain is removed by a downstream unit.

Top module: `cordic_rot_rec`

## Requirements
- R1: Step i (counting from 0) updates the vector as x ← x − σ·(y >>> i) and y ← y + σ·(x >>> i), where σ = +1 or −1. Both updates use the values from before the step. The shifts are arithmetic right shifts of 18-bit signed registers, which round toward minus infinity. The inputs are sign-extended into these registers.
- R2: Angle code 0 selects 3π/8, with σ for i = 0..10 equal to + + − + + − + + − − +. Code 1 selects 3π/16, with σ = + − + + − − − + − + +. Code 2 selects π/16, with σ = + − − + − + + + + − +.
- R3: An iteration count n from 1 to 11 runs exactly steps 0..n−1 of the selected sequence.
- R4: An iteration count of 0 returns the inputs unchanged, sign-extended to 18 bits, and done is raised in the first cycle after the accepting edge.
- R5: An iteration count above 11 behaves exactly like 11, in both result and latency.
- R6: A start is accepted at a rising edge where start is high and the block is idle. With n steps, done is high for exactly one cycle, namely the cycle that follows the n-th rising edge after the accepting edge.
- R7: A start raised while an operation is running is ignored. The running operation ends at its own time, with its own result.
- R8: Angle code 3 is reserved. A start carrying it is ignored: no done follows, and the outputs do not change.
- R9: After done, x_out and y_out hold their values until the next accepted start.
- R10: While reset is asserted, done is low and both outputs are zero.
- R11: Full-scale inputs of either sign run all 11 steps without wrap-around, because the two guard bits hold the rotated result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a rotation (one-cycle pulse) |
| angle_sel | input | 2 | 0: 3π/8, 1: 3π/16, 2: π/16, 3: reserved |
| iter_cnt | input | 4 | Number of micro-rotations; values above 11 are clamped |
| x_in | input | 16 | Signed x component |
| y_in | input | 16 | Signed y component |
| x_out | output | 18 | Signed rotated x, gain not removed |
| y_out | output | 18 | Signed rotated y, gain not removed |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
The hardest situation to reach from the ports is a new request arriving while the shared stage is partway through an earlier one. A careless controller could reload the registers or restart its step counter mid-flight. To get there, the bench holds start high with a different angle, vector and count for several cycles right after an operation has been accepted. It then checks that done still comes at the first operation's latency, and that the result equals the first operation's model value. The reserved angle code and the clamp of large counts are also driven directly, and their effect is judged only through done timing and the held outputs.

// File: rtl/cordic_rot_pkg.sv
package cordic_rot_pkg;
  // Direction masks: bit i set means a positive micro-rotation at step i.
  localparam int TBL_STEPS = 11;
  localparam logic [TBL_STEPS-1:0] SGN_3PI8  = 11'b10011011011;
  localparam logic [TBL_STEPS-1:0] SGN_3PI16 = 11'b11010001101;
  localparam logic [TBL_STEPS-1:0] SGN_PI16  = 11'b10111101001;

  typedef enum logic [1:0] {
    ANG_3PI8  = 2'd0,
    ANG_3PI16 = 2'd1,
    ANG_PI16  = 2'd2,
    ANG_RSVD  = 2'd3
  } ang_code_e;
endpackage

// File: rtl/cordic_dir_rom.sv
module cordic_dir_rom
  import cordic_rot_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  ang_code_e        ang,
  input  logic [IDX_W-1:0] idx,
  output logic             dir_pos
);
  logic [TBL_STEPS-1:0] row;
  logic [TBL_STEPS-1:0] shifted;

  always_comb begin
    unique case (ang)
      ANG_3PI8:  row = SGN_3PI8;
      ANG_3PI16: row = SGN_3PI16;
      ANG_PI16:  row = SGN_PI16;
      default:   row = '1;
    endcase
    shifted = row >> idx;
    dir_pos = shifted[0];
  end
endmodule

// File: rtl/cordic_step.sv
module cordic_step #(
  parameter int W     = 18,
  parameter int SH_W  = 4
) (
  input  logic signed [W-1:0] x_cur,
  input  logic signed [W-1:0] y_cur,
  input  logic [SH_W-1:0]     sh,
  input  logic                dir_pos,
  output logic signed [W-1:0] x_nxt,
  output logic signed [W-1:0] y_nxt
);
  logic signed [W-1:0] y_sh;
  logic signed [W-1:0] x_sh;

  always_comb begin
    y_sh = y_cur >>> sh;
    x_sh = x_cur >>> sh;
    if (dir_pos) begin
      x_nxt = x_cur - y_sh;
      y_nxt = y_cur + x_sh;
    end else begin
      x_nxt = x_cur + y_sh;
      y_nxt = y_cur - x_sh;
    end
  end
endmodule

// File: rtl/cordic_ctrl.sv
module cordic_ctrl
  import cordic_rot_pkg::*;
#(
  parameter int MAX_ITER = 11,
  parameter int ITER_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        angle_sel,
  input  logic [ITER_W-1:0] iter_cnt,
  output logic              load,
  output logic              step,
  output logic [ITER_W-1:0] cnt_q,
  output logic [ITER_W-1:0] tgt_q,
  output ang_code_e         ang_q,
  output logic              busy_q,
  output logic              done_q
);
  localparam logic [ITER_W-1:0] LIMIT = ITER_W'(MAX_ITER);

  logic [ITER_W-1:0] n_clamp;
  logic [ITER_W-1:0] cnt_d;
  logic [ITER_W-1:0] tgt_d;
  logic [ITER_W-1:0] cnt_inc;
  ang_code_e         ang_d;
  logic              busy_d;
  logic              done_d;

  always_comb begin
    n_clamp = (iter_cnt > LIMIT) ? LIMIT : iter_cnt;
    load    = start && !busy_q && (angle_sel != ANG_RSVD);
    step    = busy_q;
    cnt_inc = cnt_q + 1'b1;
    cnt_d   = cnt_q;
    tgt_d   = tgt_q;
    ang_d   = ang_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    if (load) begin
      cnt_d  = '0;
      tgt_d  = n_clamp;
      ang_d  = ang_code_e'(angle_sel);
      busy_d = (n_clamp != '0);
      done_d = (n_clamp == '0);
    end else if (busy_q) begin
      cnt_d  = cnt_inc;
      done_d = (cnt_inc == tgt_q);
      busy_d = !done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tgt_q  <= '0;
      ang_q  <= ANG_3PI8;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tgt_q  <= tgt_d;
      ang_q  <= ang_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/cordic_rot_rec.sv
module cordic_rot_rec
  import cordic_rot_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int GUARD    = 2,
  parameter int MAX_ITER = 11,
  parameter int ITER_W   = $clog2(MAX_ITER + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [1:0]                angle_sel,
  input  logic [ITER_W-1:0]         iter_cnt,
  input  logic signed [DATA_W-1:0]  x_in,
  input  logic signed [DATA_W-1:0]  y_in,
  output logic signed [DATA_W+GUARD-1:0] x_out,
  output logic signed [DATA_W+GUARD-1:0] y_out,
  output logic                      done
);
  localparam int IW = DATA_W + GUARD;

  // Reset: asynchronous assertion, synchronous release.
  logic rst_meta;
  logic rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic              load;
  logic              step;
  logic              busy;
  logic [ITER_W-1:0] cnt;
  logic [ITER_W-1:0] tgt;
  ang_code_e         ang;
  logic              dir_pos;

  cordic_ctrl #(.MAX_ITER(MAX_ITER), .ITER_W(ITER_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .angle_sel(angle_sel),
    .iter_cnt(iter_cnt), .load(load), .step(step), .cnt_q(cnt), .tgt_q(tgt),
    .ang_q(ang), .busy_q(busy), .done_q(done)
  );

  cordic_dir_rom #(.IDX_W(ITER_W)) u_rom (
    .ang(ang), .idx(cnt), .dir_pos(dir_pos)
  );

  logic signed [IW-1:0] x_q, y_q;
  logic signed [IW-1:0] x_st, y_st;
  logic signed [IW-1:0] x_d, y_d;
  logic                 vec_en;

  cordic_step #(.W(IW), .SH_W(ITER_W)) u_step (
    .x_cur(x_q), .y_cur(y_q), .sh(cnt), .dir_pos(dir_pos),
    .x_nxt(x_st), .y_nxt(y_st)
  );

  always_comb begin
    vec_en = load || step;
    if (load) begin
      x_d = IW'(x_in);
      y_d = IW'(y_in);
    end else begin
      x_d = x_st;
      y_d = y_st;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (vec_en) begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  assign x_out = x_q;
  assign y_out = y_q;
endmodule

// File: rtl/cordic_rot_rec_chk.sv
module cordic_rot_rec_chk #(
  parameter int ITER_W   = 4,
  parameter int OUT_W    = 18,
  parameter int MAX_ITER = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        angle_sel,
  input logic              done,
  input logic [OUT_W-1:0]  x_out,
  input logic [OUT_W-1:0]  y_out,
  input logic              busy,
  input logic [ITER_W-1:0] cnt,
  input logic [ITER_W-1:0] tgt
);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(tgt));

  // R8
  rsvd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && angle_sel == 2'd3) |=> (!done && !busy));

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(x_out) && $stable(y_out)));

  // R5
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt) <= MAX_ITER) && (int'(tgt) <= MAX_ITER));
endmodule

bind cordic_rot_rec cordic_rot_rec_chk #(
  .ITER_W(ITER_W), .OUT_W(DATA_W + GUARD), .MAX_ITER(MAX_ITER)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .angle_sel(angle_sel),
  .done(done), .x_out(x_out), .y_out(y_out), .busy(busy), .cnt(cnt), .tgt(tgt)
);

// File: tb/cordic_rot_rec_tb.sv
module cordic_rot_rec_tb;
  logic clk;
  logic rst_n;
  logic start;
  logic [1:0] angle_sel;
  logic [3:0] iter_cnt;
  logic signed [15:0] x_in, y_in;
  logic signed [17:0] x_out, y_out;
  logic done;

  int n_tests = 0;
  int n_fail  = 0;

  cordic_rot_rec u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .angle_sel(angle_sel),
    .iter_cnt(iter_cnt), .x_in(x_in), .y_in(y_in),
    .x_out(x_out), .y_out(y_out), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Direction signs from the requirement (R2), written as +1/-1 per step.
  function automatic int sgn(input int a, input int i);
    int s0 [11] = '{ 1, 1,-1, 1, 1,-1, 1, 1,-1,-1, 1};
    int s1 [11] = '{ 1,-1, 1, 1,-1,-1,-1, 1,-1, 1, 1};
    int s2 [11] = '{ 1,-1,-1, 1,-1, 1, 1, 1, 1,-1, 1};
    if (a == 0) return s0[i];
    if (a == 1) return s1[i];
    return s2[i];
  endfunction

  // Reference from R1: x' = x - s*(y>>>i), y' = y + s*(x>>>i), 18-bit.
  task automatic model(input int a, input int n, input int xv, input int yv,
                       output logic signed [17:0] ex, output logic signed [17:0] ey);
    logic signed [17:0] mx, my, dx, dy;
    mx = 18'(xv);
    my = 18'(yv);
    for (int i = 0; i < n; i++) begin
      dx = my >>> i;
      dy = mx >>> i;
      if (sgn(a, i) > 0) begin
        mx = mx - dx; my = my + dy;
      end else begin
        mx = mx + dx; my = my - dy;
      end
    end
    ex = mx;
    ey = my;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    while (!done && k < 30) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic run_op(input int a, input int n, input int xv, input int yv, input string req);
    logic signed [17:0] ex, ey;
    int nc, k;
    nc = (n > 11) ? 11 : n;
    model(a, nc, xv, yv, ex, ey);
    @(negedge clk);
    start = 1'b1; angle_sel = 2'(a); iter_cnt = 4'(n);
    x_in = 16'(xv); y_in = 16'(yv);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    wait_done(k);
    check(k == nc, {req, " latency"}, k, nc);
    check(x_out == ex, {req, " x"}, x_out, ex);
    check(y_out == ey, {req, " y"}, y_out, ey);
    @(negedge clk);
    check(done == 1'b0, {req, " R6 done one cycle"}, done, 0);
  endtask

  task automatic t_reset();
    check(done == 1'b0, "R10 done in reset", done, 0);
    check(x_out == 0, "R10 x in reset", x_out, 0);
    check(y_out == 0, "R10 y in reset", y_out, 0);
  endtask

  task automatic t_passthrough();
    run_op(0, 0, -1234, 567, "R4 n=0");
    check(x_out == -1234, "R4 sign-extended x", x_out, -1234);
  endtask

  task automatic t_angles();
    run_op(0, 11, 10000, 0, "R2 R3 angle 3pi/8");
    run_op(1, 11, 10000, 0, "R2 R3 angle 3pi/16");
    run_op(2, 11, 10000, 0, "R2 R3 angle pi/16");
    run_op(1, 11, -7000, 3000, "R1 mixed signs");
  endtask

  task automatic t_partial();
    run_op(2, 1, 4000, -2500, "R3 n=1");
    run_op(0, 5, 300, 9000, "R3 n=5");
    run_op(1, 10, -20000, -1, "R1 R3 n=10 floor shift");
  endtask

  task automatic t_clamp();
    run_op(2, 15, 12345, -6789, "R5 n=15");
    run_op(0, 12, -555, 777, "R5 n=12");
  endtask

  task automatic t_fullscale();
    run_op(0, 11, 32767, 32767, "R11 +full");
    run_op(2, 11, -32768, -32768, "R11 -full");
    run_op(1, 11, 32767, -32768, "R11 mixed full");
  endtask

  task automatic t_busy_start();
    logic signed [17:0] ex, ey;
    int k;
    model(0, 11, 9000, -3000, ex, ey);
    @(negedge clk);
    start = 1'b1; angle_sel = 2'd0; iter_cnt = 4'd11; x_in = 9000; y_in = -3000;
    @(posedge clk);
    @(negedge clk);
    angle_sel = 2'd2; iter_cnt = 4'd2; x_in = 100; y_in = 100;
    for (int c = 0; c < 4; c++) @(negedge clk);
    start = 1'b0;
    k = 4;
    while (!done && k < 30) begin
      @(negedge clk);
      k++;
    end
    check(k == 11, "R7 latency unaffected", k, 11);
    check(x_out == ex, "R7 x of first op", x_out, ex);
    check(y_out == ey, "R7 y of first op", y_out, ey);
    @(negedge clk);
  endtask

  task automatic t_reserved();
    logic signed [17:0] hx, hy;
    bit seen;
    hx = x_out; hy = y_out;
    seen = 1'b0;
    @(negedge clk);
    start = 1'b1; angle_sel = 2'd3; iter_cnt = 4'd3; x_in = 1; y_in = 2;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 15; c++) begin
      if (done) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, "R8 no done for code 3", seen, 0);
    check(x_out == hx, "R8 R9 x held", x_out, hx);
    check(y_out == hy, "R8 R9 y held", y_out, hy);
  endtask

  initial begin
    #1500000;
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; angle_sel = '0; iter_cnt = '0; x_in = '0; y_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_passthrough();
    t_angles();
    t_partial();
    t_clamp();
    t_fullscale();
    t_busy_start();
    t_reserved();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule